// File: doc/BRIEF.md
# Dual-Port PHY Power-Up Sequencer

This block steps two serial-link PHY lanes out of power-down and reset in one fixed order, hands control to an external configuration loader at the point where the PHYs can accept settings, then frees the lane and synthesizer resets and the link controller core. It ends with a bounded readiness poll of both PHYs.

The whole sequence is driven by one start pulse. Every wait is a cycle-count parameter, so the same RTL serves silicon timings and short simulation timings. The block drives a single 32-bit control word whose bit positions are decoded by the PHY glue next to it. It also drives a timer-scale override line.

When the poll ends, the block raises `done_o`. It latches which ports were ready in `port_up_o`, and it sets `timeout_o` if the poll budget ran out first. A new start pulse is accepted only when the block is idle or finished.

Top module: `sat_pwrseq`

## Requirements
- R1: While `rst_ni` is low and after reset until a start, `ctl_o`, `timer_scale_o`, `cfg_req_o`, `done_o`, `timeout_o` and `port_up_o` are all zero.
- R2: Control word layout:
  - bit 0 is the core release (active-low reset, 1 = released).
  - bits 2 and 3 are the master and slave low-power requests.
  - each port group holds, from its low bit up: synthesizer hard reset, lane hard reset, power-on reset, Tx power, Rx power and synthesizer power. Port 0 uses bits 12–17 and port 1 uses bits 24–29.
  - all other bits stay 0.
- R3: From the cycle after a start is sampled, `ctl_o` holds all zeros for `SHORT_CYC` cycles.
- R4: Next, only the three power bits of both ports are set (word 0x38038000), for `LONG_CYC` cycles.
- R5: Next, the port 0 power-on reset is added (0x3803C000) for `LONG_CYC` cycles. Then the port 1 power-on reset is added (0x3C03C000) for `LONG_CYC` cycles.
- R6: Then `cfg_req_o` is high, and the word is unchanged, for as long as `cfg_done_i` stays low. In the cycle after `cfg_done_i` is sampled high, `cfg_req_o` drops and the word holds for another `LONG_CYC` cycles.
- R7: Then the lane and synthesizer resets of both ports are added (0x3F03F000) for `SHORT_CYC` cycles. Then bit 0 and both low-power requests are added (0x3F03F00D) and `timer_scale_o` goes high. Both stay set through polling and done.
- R8: Polling samples `phy_rdy_i` (bit 0 = port 0, bit 1 = port 1) on its first cycle and then every `GAP_CYC` cycles. In the cycle after a sample with both bits set, `done_o` = 1, `timeout_o` = 0 and `port_up_o` = 2'b11.
- R9: If `POLL_MAX` samples all fail, the cycle after the last one shows `done_o` = 1 and `timeout_o` = 1, with `port_up_o` equal to the last sample.
- R10: A start pulse during any sequence step is ignored. A start pulse while done restarts the sequence and clears `done_o`, `timeout_o` and `port_up_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the power-up sequence |
| cfg_done_i | input | 1 | Configuration loader has finished |
| phy_rdy_i | input | 2 | Per-port PHY ready status |
| ctl_o | output | 32 | PHY and core control word |
| timer_scale_o | output | 1 | Timer-scale override |
| cfg_req_o | output | 1 | Request to the configuration loader |
| done_o | output | 1 | Sequence finished |
| timeout_o | output | 1 | Poll budget exhausted |
| port_up_o | output | 2 | Latched per-port ready result |

## Verification
The control word is a decode of the registered state, so it changes one cycle after the edge that samples start or `cfg_done_i`. Each step then lasts exactly its parameter count. The bench walks a phase table and compares the word at the falling edge of every cycle of every step.

`done_o` and its companions appear one cycle after the deciding poll sample. The bench counts the sample times from the first polling cycle (the first cycle, then every `GAP_CYC` cycles). It checks that `done_o` is still low in the sample cycle and high in the cycle after.

// File: rtl/sat_pwrseq_pkg.sv
package sat_pwrseq_pkg;
  localparam int CTL_W   = 32;
  localparam int NPORT   = 2;
  localparam int GRP_W   = 6;
  localparam int CORE_B  = 0;
  localparam int MLP_B   = 2;
  localparam int SLP_B   = 3;
  localparam int PORT_BASE [NPORT] = '{12, 24};
  // offsets inside a port group
  localparam int SYN_RST = 0;
  localparam int LN_RST  = 1;
  localparam int POR_RST = 2;
  localparam int TX_PWR  = 3;
  localparam int RX_PWR  = 4;
  localparam int SYN_PWR = 5;

  // declaration order is the release order
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_PWR, ST_POR0, ST_POR1, ST_CFG,
    ST_PRE, ST_LANE, ST_CORE, ST_POLL, ST_DONE
  } seq_st_e;
endpackage

// File: rtl/sat_pwrseq_timer.sv
module sat_pwrseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sat_pwrseq_fsm.sv
module sat_pwrseq_fsm
  import sat_pwrseq_pkg::*;
#(
  parameter int SHORT_CYC = 15000,
  parameter int LONG_CYC  = 50000,
  parameter int GAP_CYC   = 500,
  parameter int POLL_MAX  = 10000,
  parameter int TW        = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_done_i,
  input  logic [1:0]    phy_rdy_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output seq_st_e       st_o,
  output logic          cfg_req_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [1:0]    port_up_o
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [TW-1:0] SHORT_V = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_V  = TW'(LONG_CYC - 1);
  localparam logic [TW-1:0] GAP_V   = TW'(GAP_CYC - 1);
  localparam logic [PW-1:0] LAST_P  = PW'(POLL_MAX - 1);

  seq_st_e       st_q, st_d;
  logic [PW-1:0] poll_q;
  logic          both_rdy, last_poll, finish;

  assign both_rdy  = &phy_rdy_i;
  assign last_poll = (poll_q == LAST_P);
  assign finish    = (st_q == ST_POLL) && tmr_zero_i && (both_rdy || last_poll);

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_IDLE, ST_DONE:
        if (start_i) begin st_d = ST_CLR; tmr_load_o = 1'b1; tmr_val_o = SHORT_V; end
      ST_CLR:
        if (tmr_zero_i) begin st_d = ST_PWR; tmr_load_o = 1'b1; tmr_val_o = LONG_V; end
      ST_PWR:
        if (tmr_zero_i) begin st_d = ST_POR0; tmr_load_o = 1'b1; tmr_val_o = LONG_V; end
      ST_POR0:
        if (tmr_zero_i) begin st_d = ST_POR1; tmr_load_o = 1'b1; tmr_val_o = LONG_V; end
      ST_POR1:
        if (tmr_zero_i) st_d = ST_CFG;
      ST_CFG:
        if (cfg_done_i) begin st_d = ST_PRE; tmr_load_o = 1'b1; tmr_val_o = LONG_V; end
      ST_PRE:
        if (tmr_zero_i) begin st_d = ST_LANE; tmr_load_o = 1'b1; tmr_val_o = SHORT_V; end
      ST_LANE:
        if (tmr_zero_i) st_d = ST_CORE;
      ST_CORE: begin
        st_d = ST_POLL; tmr_load_o = 1'b1; tmr_val_o = '0;
      end
      ST_POLL:
        if (finish) st_d = ST_DONE;
        else if (tmr_zero_i) begin tmr_load_o = 1'b1; tmr_val_o = GAP_V; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      poll_q    <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      port_up_o <= 2'b00;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CORE) poll_q <= '0;
      else if (st_q == ST_POLL && tmr_zero_i && !finish) poll_q <= poll_q + 1'b1;
      if (finish) begin
        done_o    <= 1'b1;
        timeout_o <= !both_rdy;
        port_up_o <= phy_rdy_i;
      end else if (st_q == ST_DONE && start_i) begin
        done_o    <= 1'b0;
        timeout_o <= 1'b0;
        port_up_o <= 2'b00;
      end
    end
  end

  assign st_o      = st_q;
  assign cfg_req_o = (st_q == ST_CFG);

  // R6
  cfg_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_req_o) |-> $past(cfg_done_i));
  // R9
  timeout_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  // R8
  ready_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !timeout_o) |-> $past(&phy_rdy_i));
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(st_q inside {ST_IDLE, ST_DONE, ST_CLR})) |=> (st_q != ST_CLR));
endmodule

// File: rtl/sat_pwrseq_ctl.sv
module sat_pwrseq_ctl
  import sat_pwrseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          st_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             timer_scale_o
);
  logic pwr_on, lane_rel, core_rel;
  logic [NPORT-1:0] por_rel;
  logic [NPORT-1:0][GRP_W-1:0] grp;

  assign pwr_on     = (st_i >= ST_PWR);
  assign por_rel[0] = (st_i >= ST_POR0);
  assign por_rel[1] = (st_i >= ST_POR1);
  assign lane_rel   = (st_i >= ST_LANE);
  assign core_rel   = (st_i >= ST_CORE);

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_comb begin
      grp[g]          = '0;
      grp[g][SYN_RST] = lane_rel;
      grp[g][LN_RST]  = lane_rel;
      grp[g][POR_RST] = por_rel[g];
      grp[g][TX_PWR]  = pwr_on;
      grp[g][RX_PWR]  = pwr_on;
      grp[g][SYN_PWR] = pwr_on;
    end
  end

  always_comb begin
    ctl_o         = '0;
    ctl_o[CORE_B] = core_rel;
    ctl_o[MLP_B]  = core_rel;
    ctl_o[SLP_B]  = core_rel;
    for (int p = 0; p < NPORT; p++)
      ctl_o[PORT_BASE[p] +: GRP_W] = grp[p];
  end

  assign timer_scale_o = core_rel;

  // R5
  por_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[PORT_BASE[1] + POR_RST] |-> ctl_o[PORT_BASE[0] + POR_RST]);
  // R7
  core_after_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[CORE_B] |-> (timer_scale_o && ctl_o[PORT_BASE[0] + LN_RST] && ctl_o[PORT_BASE[1] + SYN_RST]));
endmodule

// File: rtl/sat_pwrseq.sv
module sat_pwrseq
  import sat_pwrseq_pkg::*;
#(
  parameter int SHORT_CYC = 15000,
  parameter int LONG_CYC  = 50000,
  parameter int GAP_CYC   = 500,
  parameter int POLL_MAX  = 10000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        cfg_done_i,
  input  logic [1:0]  phy_rdy_i,
  output logic [31:0] ctl_o,
  output logic        timer_scale_o,
  output logic        cfg_req_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic [1:0]  port_up_o
);
  localparam int MAXD = (LONG_CYC > SHORT_CYC) ?
                        ((LONG_CYC > GAP_CYC) ? LONG_CYC : GAP_CYC) :
                        ((SHORT_CYC > GAP_CYC) ? SHORT_CYC : GAP_CYC);
  localparam int TW = $clog2(MAXD + 1);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  seq_st_e       st;

  sat_pwrseq_timer #(.TW(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .val_i (tmr_val), .zero_o(tmr_zero)
  );

  sat_pwrseq_fsm #(
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC),
    .GAP_CYC(GAP_CYC), .POLL_MAX(POLL_MAX), .TW(TW)
  ) u_fsm (
    .clk_i     (clk_i),      .rst_ni    (rst_ni),
    .start_i   (start_i),    .cfg_done_i(cfg_done_i),
    .phy_rdy_i (phy_rdy_i),  .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load),   .tmr_val_o (tmr_val),
    .st_o      (st),         .cfg_req_o (cfg_req_o),
    .done_o    (done_o),     .timeout_o (timeout_o),
    .port_up_o (port_up_o)
  );

  sat_pwrseq_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st),
    .ctl_o(ctl_o), .timer_scale_o(timer_scale_o)
  );
endmodule

// File: tb/sim_sat_pwrseq.sv
`timescale 1ns/1ps
module sim_sat_pwrseq;
  localparam int S = 3, L = 5, G = 4, PM = 6;
  // R2 word values
  localparam logic [31:0] W_PWR  = 32'h3803_8000;
  localparam logic [31:0] W_POR0 = W_PWR  | (32'h1 << 14);
  localparam logic [31:0] W_POR1 = W_POR0 | (32'h1 << 26);
  localparam logic [31:0] W_LANE = W_POR1 | (32'h3 << 12) | (32'h3 << 24);
  localparam logic [31:0] W_CORE = W_LANE | 32'hD;
  // phase table: CLR, PWR, POR0, POR1, PRE, LANE, CORE (cfg wait before index 4)
  localparam int          PH_LEN [7] = '{S, L, L, L, L, S, 1};
  localparam logic [31:0] PH_W   [7] = '{32'h0, W_PWR, W_POR0, W_POR1, W_POR1, W_LANE, W_CORE};
  localparam string       PH_R   [7] = '{"R3", "R4", "R5", "R5", "R6", "R7", "R7"};

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, cfg_done_i = 1'b0;
  logic [1:0] phy_rdy_i = 2'b00;
  logic [31:0] ctl_o;
  logic timer_scale_o, cfg_req_o, done_o, timeout_o;
  logic [1:0] port_up_o;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  sat_pwrseq #(.SHORT_CYC(S), .LONG_CYC(L), .GAP_CYC(G), .POLL_MAX(PM)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cfg_done_i(cfg_done_i),
    .phy_rdy_i(phy_rdy_i), .ctl_o(ctl_o), .timer_scale_o(timer_scale_o),
    .cfg_req_o(cfg_req_o), .done_o(done_o), .timeout_o(timeout_o),
    .port_up_o(port_up_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // walks start..CORE; returns at the negedge of the first polling cycle
  task automatic walk(input bit poke);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", {29'b0, done_o, timeout_o, |port_up_o}, 32'h0);
    for (int p = 0; p < 7; p++) begin
      if (p == 4) begin
        for (int k = 0; k < 6; k++) begin
          chk("R6", {31'b0, cfg_req_o}, 32'h1);
          chk("R6", ctl_o, W_POR1);
          if (poke && k == 2) start_i = 1'b1;   // R10: ignored while running
          if (k == 3) start_i = 1'b0;
          @(negedge clk);
        end
        cfg_done_i = 1'b1;
        @(negedge clk);
        cfg_done_i = 1'b0;
        chk("R6", {31'b0, cfg_req_o}, 32'h0);
      end
      for (int k = 0; k < PH_LEN[p]; k++) begin
        chk(PH_R[p], ctl_o, PH_W[p]);
        chk("R7", {31'b0, timer_scale_o}, {31'b0, p == 6});
        if (poke && p == 2 && k == 0) start_i = 1'b1;  // R10
        if (poke && p == 2 && k == 1) start_i = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", ctl_o, 32'h0);
    chk("R1", {26'b0, timer_scale_o, cfg_req_o, done_o, timeout_o, port_up_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", ctl_o, 32'h0);

    // run A: both ready at once, with stray start pulses
    phy_rdy_i = 2'b11;
    walk(1'b1);
    chk("R8", {31'b0, done_o}, 32'h0);
    @(negedge clk);
    chk("R8", {31'b0, done_o}, 32'h1);
    chk("R8", {31'b0, timeout_o}, 32'h0);
    chk("R8", {30'b0, port_up_o}, 32'h3);
    chk("R7", ctl_o, W_CORE);
    chk("R2", ctl_o & ~(32'h3F03F00D), 32'h0);

    // run B: restart from done; port 1 never ready -> timeout
    phy_rdy_i = 2'b01;
    walk(1'b0);
    repeat ((PM - 1) * G) @(negedge clk);
    chk("R9", {31'b0, done_o}, 32'h0);
    @(negedge clk);
    chk("R9", {31'b0, done_o}, 32'h1);
    chk("R9", {31'b0, timeout_o}, 32'h1);
    chk("R9", {30'b0, port_up_o}, 32'h1);
    chk("R7", {31'b0, timer_scale_o}, 32'h1);

    // run C: ready arrives after first failed sample
    phy_rdy_i = 2'b00;
    walk(1'b0);
    @(negedge clk);
    phy_rdy_i = 2'b11;
    repeat (G - 1) @(negedge clk);
    chk("R8", {31'b0, done_o}, 32'h0);
    @(negedge clk);
    chk("R8", {31'b0, done_o}, 32'h1);
    chk("R8", {31'b0, timeout_o}, 32'h0);
    chk("R8", {30'b0, port_up_o}, 32'h3);

    // R10: start held off, done stays
    repeat (3) @(negedge clk);
    chk("R10", {31'b0, done_o}, 32'h1);
    finish_run();
  end
endmodule